// File: doc/BRIEF.md
# Iterative Right-Shift Execution Unit

This block executes the two right-shift instructions of a CISC-style processor: a logical shift that fills the vacated top bit with zero, and an arithmetic shift that keeps the top bit so the sign is preserved. A byte (8-bit) or word (16-bit) operand arrives on a port together with the first opcode byte, the 3-bit operation field of the addressing byte, the current CL register value and the immediate count byte. The unit decodes the opcode byte to pick the operand width and where the shift count comes from. The count can be a fixed one, the CL value or the immediate byte. The unit then moves the operand right by one bit per clock until the count is used up.

When the count is exhausted, the unit registers the result together with carry, overflow, sign, zero and parity flags, and pulses done for one cycle. Operand fetch, write-back, address calculation and instruction length are handled elsewhere. The flag outputs keep their values between operations, so a shift with a zero count leaves them as they were.

Top module: `rshift_exec`

## Requirements
- R1: Opcode byte bits [7:1] = 1101000 select a count of one, 1101001 select the CL count and 1100000 select the immediate count. Bit 0 = 1 selects a word operand and 0 a byte operand. Operation field 101 selects the logical shift and 111 the arithmetic shift. A start carrying any other opcode or field value is ignored: busy stays low and no done follows.
- R2: For the logical shift, the result is the operand at the selected width moved right by the full 8-bit count, with zeros entering at the top. A byte shift by 8 or more gives 0, and result bits [15:8] are 0 for byte operations.
- R3: For the arithmetic shift, the top bit at the selected width (bit 7 for a byte, bit 15 for a word) is copied into the vacated positions on every step. A count at or above the width gives all copies of the sign bit.
- R4: After a non-zero count n, flag_cy holds the last bit shifted out. That is operand bit n-1 when n is at most the width, and otherwise the sign bit for the arithmetic shift or 0 for the logical shift.
- R5: In the count-of-one forms, flag_v becomes top bit XOR the next lower bit of the operand for the logical shift, and 0 for the arithmetic shift. The CL and immediate forms leave flag_v unchanged.
- R6: After a non-zero count, flag_s is the top bit of the result at the selected width, flag_z is 1 when the result at that width is zero, and flag_p is 1 when result bits [7:0] hold an even number of ones.
- R7: A zero count returns the operand unchanged and leaves all five flags at their prior values. Done still pulses.
- R8: With the accepting clock edge counted as the first, done is a single-cycle pulse raised by edge count+2, so the count is consumed at one bit per clock.
- R9: A start that arrives while busy is high is ignored and does not disturb the operation in progress.
- R10: After reset, result and all flags are 0 and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opc | input | 8 | First opcode byte |
| op_field | input | 3 | Operation field of the addressing byte |
| opnd | input | 16 | Operand; bits [7:0] used for byte operations |
| cl_val | input | 8 | Current CL register value |
| imm_val | input | 8 | Immediate count byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted operand |
| flag_cy | output | 1 | Carry: last bit shifted out |
| flag_v | output | 1 | Overflow |
| flag_s | output | 1 | Sign of result |
| flag_z | output | 1 | Result is zero |
| flag_p | output | 1 | Even parity of result low byte |

## Verification
A wrong step counter shows up first as done arriving early or late, and then as a result shifted by the wrong amount. Both are visible at the first completion after the fault. A corrupted accumulator or a wrongly held mode bit changes the result and the sign flag of that same operation. A flag register that updates when it should hold only shows at a later zero-count shift or at a later multi-step shift (for overflow). For that reason the stimulus interleaves zero counts and count-of-one forms with the long shifts. A decoder that accepts an illegal code or a start during busy produces a done that the scoreboard has no entry for.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
  typedef enum logic [1:0] {CSRC_ONE, CSRC_CL, CSRC_IMM, CSRC_NONE} cnt_src_e;

  typedef struct packed {
    logic valid;
    logic arith;
    logic wide;
    logic one_form;
  } shift_op_t;

  typedef enum logic {ST_IDLE, ST_RUN} rsh_state_e;
endpackage

// File: rtl/rshift_decode.sv
module rshift_decode #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [7:0]         opc,
  input  logic [2:0]         op_field,
  input  logic [CNT_W-1:0]   cl_val,
  input  logic [CNT_W-1:0]   imm_val,
  output rshift_pkg::shift_op_t dec,
  output logic [CNT_W-1:0]   count
);
  import rshift_pkg::*;

  localparam logic [6:0] OPC_ONE = 7'b1101000;
  localparam logic [6:0] OPC_CL  = 7'b1101001;
  localparam logic [6:0] OPC_IMM = 7'b1100000;
  localparam logic [2:0] FLD_LOG = 3'b101;
  localparam logic [2:0] FLD_ARI = 3'b111;

  cnt_src_e src;
  logic     field_ok;

  always_comb begin
    unique case (opc[7:1])
      OPC_ONE: src = CSRC_ONE;
      OPC_CL:  src = CSRC_CL;
      OPC_IMM: src = CSRC_IMM;
      default: src = CSRC_NONE;
    endcase
  end

  assign field_ok = (op_field == FLD_LOG) || (op_field == FLD_ARI);

  always_comb begin
    dec.valid    = field_ok && (src != CSRC_NONE);
    dec.arith    = (op_field == FLD_ARI);
    dec.wide     = opc[0];
    dec.one_form = (src == CSRC_ONE);
    unique case (src)
      CSRC_ONE: count = CNT_W'(1);
      CSRC_CL:  count = cl_val;
      CSRC_IMM: count = imm_val;
      default:  count = '0;
    endcase
  end
endmodule

// File: rtl/rshift_datapath.sv
module rshift_datapath #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step_en,
  input  logic [WORD_W-1:0] load_val,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              load_wide,
  input  logic              load_arith,
  output logic [WORD_W-1:0] acc,
  output logic              cnt_zero,
  output logic              last_cy,
  output logic              stepped,
  output logic              wide_q,
  output logic              arith_q
);
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] BYTE_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [CNT_W-1:0] cnt;
  logic [WORD_W:0]  nxt;

  function automatic logic top_bit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  // One step: returns {bit shifted out, new value}.
  function automatic logic [WORD_W:0] shift_one(input logic [WORD_W-1:0] v,
                                                input logic wide, input logic arith);
    logic [WORD_W-1:0] n;
    n = v >> 1;
    if (arith) begin
      if (wide) n[WORD_W-1] = v[WORD_W-1];
      else      n[BYTE_W-1] = v[BYTE_W-1];
    end
    return {v[0], n};
  endfunction

  assign nxt      = shift_one(acc, wide_q, arith_q);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      cnt     <= '0;
      last_cy <= 1'b0;
      stepped <= 1'b0;
      wide_q  <= 1'b0;
      arith_q <= 1'b0;
    end else if (load) begin
      acc     <= load_wide ? load_val : (load_val & BYTE_MASK);
      cnt     <= load_cnt;
      stepped <= 1'b0;
      wide_q  <= load_wide;
      arith_q <= load_arith;
    end else if (step_en) begin
      acc     <= nxt[WORD_W-1:0];
      last_cy <= nxt[WORD_W];
      cnt     <= cnt - 1'b1;
      stepped <= 1'b1;
    end
  end

  assert_sign_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && arith_q) |=> (top_bit(acc, wide_q) == $past(top_bit(acc, wide_q))));

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !arith_q) |=> (top_bit(acc, wide_q) == 1'b0));

  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_byte_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wide_q) |=> (acc[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/rshift_flags.sv
module rshift_flags #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              stepped,
  input  logic [WORD_W-1:0] acc,
  input  logic              wide,
  input  logic              last_cy,
  input  logic              one_form,
  input  logic              v_one,
  output logic [WORD_W-1:0] result,
  output logic              f_cy,
  output logic              f_v,
  output logic              f_s,
  output logic              f_z,
  output logic              f_p
);
  localparam int unsigned BYTE_W = WORD_W / 2;

  function automatic logic sign_of(input logic [WORD_W-1:0] v, input logic w);
    return w ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  function automatic logic zero_of(input logic [WORD_W-1:0] v, input logic w);
    return w ? (v == '0) : (v[BYTE_W-1:0] == '0);
  endfunction

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      f_cy   <= 1'b0;
      f_v    <= 1'b0;
      f_s    <= 1'b0;
      f_z    <= 1'b0;
      f_p    <= 1'b0;
    end else if (commit) begin
      result <= acc;
      if (stepped) begin
        f_cy <= last_cy;
        f_s  <= sign_of(acc, wide);
        f_z  <= zero_of(acc, wide);
        f_p  <= even_par(acc[BYTE_W-1:0]);
        if (one_form) f_v <= v_one;
      end
    end
  end

  assert_zero_count_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !stepped) |=> $stable({f_cy, f_v, f_s, f_z, f_p}));

  assert_parity_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && stepped) |=> (f_p == ~^result[BYTE_W-1:0]));

  assert_v_kept_multi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !one_form) |=> $stable(f_v));
endmodule

// File: rtl/rshift_exec.sv
module rshift_exec #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opc,
  input  logic [2:0]        op_field,
  input  logic [WORD_W-1:0] opnd,
  input  logic [CNT_W-1:0]  cl_val,
  input  logic [CNT_W-1:0]  imm_val,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              flag_cy,
  output logic              flag_v,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_p
);
  import rshift_pkg::*;

  localparam int unsigned BYTE_W = WORD_W / 2;

  rsh_state_e       state;
  shift_op_t        dec;
  logic [CNT_W-1:0] dec_cnt;
  logic             accept, step_en, finish;
  logic [WORD_W-1:0] acc;
  logic             cnt_zero, last_cy, stepped, wide_q, arith_q;
  logic             one_form_q, v_pend;

  function automatic logic v_single(input logic [WORD_W-1:0] v, input logic wide,
                                    input logic arith);
    if (arith) return 1'b0;
    return wide ? (v[WORD_W-1] ^ v[WORD_W-2]) : (v[BYTE_W-1] ^ v[BYTE_W-2]);
  endfunction

  rshift_decode #(.CNT_W(CNT_W)) u_decode (
    .opc(opc), .op_field(op_field), .cl_val(cl_val), .imm_val(imm_val),
    .dec(dec), .count(dec_cnt)
  );

  assign busy    = (state == ST_RUN);
  assign accept  = start && !busy && dec.valid;
  assign step_en = busy && !cnt_zero;
  assign finish  = busy && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      one_form_q <= 1'b0;
      v_pend     <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state      <= ST_RUN;
        one_form_q <= dec.one_form;
        v_pend     <= v_single(opnd, dec.wide, dec.arith);
      end else if (finish) begin
        state <= ST_IDLE;
      end
    end
  end

  rshift_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rst_n(rst_n), .load(accept), .step_en(step_en),
    .load_val(opnd), .load_cnt(dec_cnt), .load_wide(dec.wide), .load_arith(dec.arith),
    .acc(acc), .cnt_zero(cnt_zero), .last_cy(last_cy), .stepped(stepped),
    .wide_q(wide_q), .arith_q(arith_q)
  );

  rshift_flags #(.WORD_W(WORD_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .commit(finish), .stepped(stepped), .acc(acc),
    .wide(wide_q), .last_cy(last_cy), .one_form(one_form_q), .v_one(v_pend),
    .result(result), .f_cy(flag_cy), .f_v(flag_v), .f_s(flag_s), .f_z(flag_z),
    .f_p(flag_p)
  );

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cnt_zero) |=> busy);

  assert_bad_code_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !dec.valid) |=> !busy);

  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/rshift_exec_bench.sv
module rshift_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opc = '0;
  logic [2:0]  op_field = '0;
  logic [15:0] opnd = '0;
  logic [7:0]  cl_val = '0;
  logic [7:0]  imm_val = '0;
  logic        busy, done, flag_cy, flag_v, flag_s, flag_z, flag_p;
  logic [15:0] result;

  always #10 clk = ~clk;

  rshift_exec u_rshift_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .opc(opc), .op_field(op_field),
    .opnd(opnd), .cl_val(cl_val), .imm_val(imm_val), .busy(busy), .done(done),
    .result(result), .flag_cy(flag_cy), .flag_v(flag_v), .flag_s(flag_s),
    .flag_z(flag_z), .flag_p(flag_p)
  );

  typedef struct {
    logic [15:0] res;
    logic        cy, v, s, z, p;
    int          lat;
    int          t0;
    logic        arith;
    logic        zero_cnt;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic m_cy = 0, m_v = 0, m_s = 0, m_z = 0, m_p = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // Driver: computes expectation with its own model, then pulses start.
  task automatic issue(input logic [7:0] o, input logic [2:0] f, input logic [15:0] d,
                       input logic [7:0] c, input logic [7:0] im);
    exp_t e;
    logic [7:0] n;
    logic wide, ari, msb;
    int w;
    logic [7:0] rb;
    while (busy) @(negedge clk);
    wide = o[0];
    ari  = (f == 3'd7);
    w    = wide ? 16 : 8;
    if (o[7:1] == 7'h68) n = 8'd1;
    else if (o[7:1] == 7'h69) n = c;
    else n = im;
    msb = wide ? d[15] : d[7];
    if (wide) begin
      if (ari) e.res = $signed(d) >>> n;
      else     e.res = d >> n;
    end else begin
      if (ari) rb = $signed(d[7:0]) >>> n;
      else     rb = d[7:0] >> n;
      e.res = {8'h00, rb};
    end
    if (n != 0) begin
      if (int'(n) <= w) m_cy = d[n-1];
      else m_cy = ari ? msb : 1'b0;
      m_s = wide ? e.res[15] : e.res[7];
      m_z = wide ? (e.res == 16'h0) : (e.res[7:0] == 8'h0);
      m_p = ($countones(e.res[7:0]) % 2) == 0;
      if (o[7:1] == 7'h68) m_v = ari ? 1'b0 : (wide ? d[15] ^ d[14] : d[7] ^ d[6]);
    end
    e.cy = m_cy; e.v = m_v; e.s = m_s; e.z = m_z; e.p = m_p;
    e.lat = int'(n) + 2;
    e.t0 = cyc;
    e.arith = ari;
    e.zero_cnt = (n == 0);
    q.push_back(e);
    opc = o; op_field = f; opnd = d; cl_val = c; imm_val = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: scoreboard compare on each done.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "unexpected done (R9)", 1, 0);
        end else begin
          e = q.pop_front();
          check(result == e.res, e.zero_cnt ? "R7" : (e.arith ? "R3" : "R2"),
                "result", int'(result), int'(e.res));
          check(flag_cy == e.cy, e.zero_cnt ? "R7" : "R4", "cy", int'(flag_cy), int'(e.cy));
          check(flag_v == e.v, "R5", "v", int'(flag_v), int'(e.v));
          check({flag_s, flag_z, flag_p} == {e.s, e.z, e.p}, e.zero_cnt ? "R7" : "R6",
                "szp", int'({flag_s, flag_z, flag_p}), int'({e.s, e.z, e.p}));
          check(cyc - e.t0 == e.lat, "R8", "latency", cyc - e.t0, e.lat);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({busy, done} == 2'b00, "R10", "busy/done", int'({busy, done}), 0);
    check(result == 16'h0, "R10", "result", int'(result), 0);
    check({flag_cy, flag_v, flag_s, flag_z, flag_p} == 5'b0, "R10", "flags",
          int'({flag_cy, flag_v, flag_s, flag_z, flag_p}), 0);

    // Directed corners (R1 encodings, R2 R3 R4 R5 R6 R7)
    issue(8'hD0, 3'd5, 16'h0081, 8'd0, 8'd0);   // byte logical by one, V=1
    issue(8'hD1, 3'd7, 16'h8000, 8'd0, 8'd0);   // word arith by one, V=0
    issue(8'hD2, 3'd5, 16'h00A5, 8'd0, 8'd0);   // CL zero count
    issue(8'hC0, 3'd5, 16'hFFFF, 8'd0, 8'd8);   // byte logical by 8
    issue(8'hC0, 3'd7, 16'h0080, 8'd0, 8'd200); // byte arith big count
    issue(8'hC1, 3'd5, 16'h1234, 8'd0, 8'd255); // word logical max count
    issue(8'hD3, 3'd7, 16'h8001, 8'd16, 8'd0);  // word arith by 16 via CL
    issue(8'hC1, 3'd7, 16'h4000, 8'd0, 8'd0);   // imm zero count

    // R9: start during busy is ignored
    issue(8'hD3, 3'd5, 16'hF0F0, 8'd30, 8'd0);
    repeat (3) @(negedge clk);
    opc = 8'hD0; op_field = 3'd5; opnd = 16'h0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!busy, "R9", "busy after ignored start", int'(busy), 0);

    // R1: illegal opcode and illegal field are ignored
    seen = 1'b0;
    opc = 8'hD4; op_field = 3'd5; start = 1'b1;
    @(negedge clk);
    opc = 8'hD0; op_field = 3'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      if (busy || done) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R1", "illegal code accepted", int'(seen), 0);

    // Random forms at both widths (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 300; i++) begin
      logic [7:0] o;
      logic [7:0] cc;
      int k;
      k = $urandom_range(0, 2);
      o = (k == 0) ? 8'hD0 : ((k == 1) ? 8'hD2 : 8'hC0);
      o[0] = $urandom_range(0, 1);
      cc = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255))
                                       : 8'($urandom_range(0, 20));
      issue(o, ($urandom_range(0, 1) == 1) ? 3'd7 : 3'd5, 16'($urandom),
            cc, 8'(cc ^ 8'($urandom_range(0, 3))));
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule